// File: doc/BRIEF.md
# Two-Point Non-Uniformity Correction

This block removes the fixed-pattern response spread of an infrared focal-plane array. Every detector element gets its own gain and its own offset, so that after correction a uniform scene yields a uniform picture. The coefficients are produced inside the block by a calibration run. The run watches two uniform reference scenes, a cold one and a hot one, and derives each element's gain and offset from them. The results go into on-chip coefficient storage and are not recomputed during operation.

After calibration the block sits in the raster path of the sensor. Every incoming pixel is paired with its stored coefficient word, and the block emits one corrected pixel per accepted input pixel after a fixed two-cycle delay, at full rate. Until a calibration run has finished, incoming pixels produce no output. The frame size is set by parameter. The target sensor is 384x288, and the defaults are kept small so that the elaborated storage stays modest.

Top module: `nuc_core`

## Requirements
- R1: After reset `cal_busy`, `cal_done` and `out_valid` are all 0.
- R2: A cycle with `cal_start` high moves the block into calibration from any state, so that in the next cycle `cal_busy` is 1 and `cal_done` is 0. A pixel presented in that same cycle is neither captured nor corrected. A second `cal_start` during a run restarts the run.
- R3: Pixels are 14-bit unsigned. A frame is `IMG_W*IMG_H` accepted pixels (`pix_valid` high) in raster order, and pixel index 0 is the pixel carrying `pix_sof`. In calibration the first frame that starts with `pix_sof` is the cold reference and the next one is the hot reference. Valid pixels before that first `pix_sof`, and cycles with `pix_valid` low, are ignored.
- R4: Each reference mean is the floor of the sum of that frame's pixels divided by the pixel count. Feeding the cold reference frame back through correction therefore yields the cold mean at every pixel whose gain and offset are not clipped.
- R5: Gain is unsigned Q2.14 (16 bits, 14 fraction bits), equal to floor(|meanH-meanL|*2^14 / |H-L|). It is 0 when the two differences have opposite signs and saturates at 65535.
- R6: A pixel whose hot and cold values are equal gets gain 16384 (1.0) and no division is performed for it.
- R7: Offset is signed 16-bit, equal to meanL - floor(gain*L/2^14), saturated to -32768..32767.
- R8: `cal_done` rises only after every pixel's coefficients are stored, and it stays high until the next `cal_start`. While `cal_done` is high, `cal_busy` is low.
- R9: A pixel accepted while `cal_done` is high produces `out_valid` exactly two cycles later. `out_pix` equals floor(gain*in/2^14)+offset, clamped to 0..16383.
- R10: Pixels presented while `cal_done` is low produce no `out_valid`.
- R11: Correction accepts a pixel every cycle, with no gaps needed between frames or pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Begin (or restart) a calibration run |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_data | input | PW (14) | Raw detector sample |
| cal_busy | output | 1 | Calibration run in progress |
| cal_done | output | 1 | Coefficients valid, correction enabled |
| out_valid | output | 1 | Corrected pixel present |
| out_pix | output | PW (14) | Corrected, clamped pixel |

## Verification
The start of a new calibration can fall in the same cycle as a pixel that correction would otherwise accept. The bench provokes this by raising `cal_start` together with a mid-frame pixel of a correction frame. It also restarts a run partway through a cold-frame capture. A behavioural model in the bench predicts, for every clock, whether an output must appear and what it must be. The colliding pixel must yield no output. The pixels after it must be silently dropped. The restarted run must derive its coefficients only from the frames that follow the final start.

// File: rtl/nuc_pkg.sv
package nuc_pkg;

    // Calibration sequencer states; order follows the run sequence.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAPL,
        ST_CAPH,
        ST_MEANL,
        ST_MEANH,
        ST_CRD,
        ST_CGO,
        ST_CDIV,
        ST_CWR,
        ST_DONE
    } nuc_state_e;

endpackage

// File: rtl/nuc_ram.sv
module nuc_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Simple dual-port array with one cycle of read latency.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/nuc_div.sv
module nuc_div #(
    parameter int NW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);

    localparam int CW = $clog2(NW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW-1:0] rem;
        logic [NW-1:0] quo;
        logic [NW-1:0] den;
    } div_t;

    div_t s_q, s_d;
    logic [NW:0] shifted;
    logic [NW:0] trial;

    // Restoring division, one quotient bit per cycle.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.rem, s_q.quo[NW-1]};
        trial    = shifted - {1'b0, s_q.den};
        if (abort) begin
            s_d.busy = 1'b0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(NW);
            s_d.rem  = '0;
            s_d.quo  = num;
            s_d.den  = den;
        end else if (s_q.busy) begin
            if (!trial[NW]) begin
                s_d.rem = trial[NW-1:0];
                s_d.quo = {s_q.quo[NW-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[NW-1:0];
                s_d.quo = {s_q.quo[NW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign quo  = s_q.quo;

endmodule

// File: rtl/nuc_apply.sv
module nuc_apply #(
    parameter int PW = 14,
    parameter int GW = 16,
    parameter int GF = 14,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [PW-1:0]        in_pix,
    input  logic [GW-1:0]        gain,
    input  logic signed [OW-1:0] offset,
    output logic                 out_valid,
    output logic [PW-1:0]        out_pix
);

    localparam int PRW  = GW + PW;
    localparam int SCW  = PRW - GF;
    localparam int SUMW = ((SCW > OW) ? SCW : OW) + 2;
    localparam logic signed [SUMW-1:0] TOP = SUMW'(2**PW - 1);

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] pix;
    } app_t;

    app_t s_q, s_d;
    logic [PRW-1:0]         prod;
    logic signed [SUMW-1:0] scaled;
    logic signed [SUMW-1:0] wide_off;
    logic signed [SUMW-1:0] total;

    // One multiply, one add, then clamp to the pixel range.
    always_comb begin
        prod     = PRW'(gain) * PRW'(in_pix);
        scaled   = $signed(SUMW'(prod >> GF));
        wide_off = SUMW'(offset);
        total    = scaled + wide_off;
        s_d.valid = in_valid;
        if (total < 0)        s_d.pix = '0;
        else if (total > TOP) s_d.pix = '1;
        else                  s_d.pix = total[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_pix   = s_q.pix;

endmodule

// File: rtl/nuc_core.sv
module nuc_core
    import nuc_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 24,
    parameter int PW    = 14,
    parameter int GW    = 16,
    parameter int GF    = 14,
    parameter int OW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_start,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic [PW-1:0] pix_data,
    output logic          cal_busy,
    output logic          cal_done,
    output logic          out_valid,
    output logic [PW-1:0] out_pix
);

    localparam int NPIX = IMG_W * IMG_H;
    localparam int AW   = $clog2(NPIX);
    localparam int SW   = PW + AW;
    localparam int NW   = (SW > PW + GF) ? SW : PW + GF;
    localparam int CWID = GW + OW;
    localparam int PRW  = GW + PW;
    localparam int OFW  = PRW - GF + 2;
    localparam logic [GW-1:0] UNITY = GW'(2**GF);
    localparam logic signed [OFW-1:0] OFS_HI = OFW'(2**(OW-1) - 1);
    localparam logic signed [OFW-1:0] OFS_LO = OFW'(-(2**(OW-1)));

    typedef struct packed {
        nuc_state_e    st;
        logic          armed;
        logic          launched;
        logic          neg;
        logic [AW-1:0] idx;
        logic [AW-1:0] cidx;
        logic [SW-1:0] sum_l;
        logic [SW-1:0] sum_h;
        logic [PW-1:0] mean_l;
        logic [PW-1:0] mean_h;
        logic [PW-1:0] li;
        logic [GW-1:0] gain;
        logic          v1;
        logic [PW-1:0] p1;
    } core_t;

    core_t s_q, s_d;

    logic [AW-1:0]   pix_addr;
    logic            last_pix;
    logic            cap_acc, corr_acc;
    logic            lo_we, hi_we, coef_we;
    logic [PW-1:0]   lo_rd, hi_rd;
    logic [CWID-1:0] coef_rd;
    logic            div_start, div_done;
    logic [NW-1:0]   div_num, div_den, div_quo;
    logic signed [PW:0]    dif, dmean;
    logic [PW-1:0]         abs_dif, abs_dm;
    logic [PRW-1:0]        gl;
    logic signed [OFW-1:0] ofs;
    logic [OW-1:0]         off_sat;

    assign pix_addr = pix_sof ? '0 : s_q.idx;
    assign last_pix = (pix_addr == AW'(NPIX - 1));
    assign cap_acc  = pix_valid && !cal_start && (pix_sof || s_q.armed);
    assign corr_acc = (s_q.st == ST_DONE) && pix_valid && !cal_start;

    always_comb begin
        dif     = $signed({1'b0, hi_rd}) - $signed({1'b0, lo_rd});
        dmean   = $signed({1'b0, s_q.mean_h}) - $signed({1'b0, s_q.mean_l});
        abs_dif = dif[PW] ? PW'(-dif) : dif[PW-1:0];
        abs_dm  = dmean[PW] ? PW'(-dmean) : dmean[PW-1:0];
        gl      = PRW'(s_q.gain) * PRW'(s_q.li);
        ofs     = $signed(OFW'(s_q.mean_l)) - $signed(OFW'(gl >> GF));
        if (ofs > OFS_HI)      off_sat = OFS_HI[OW-1:0];
        else if (ofs < OFS_LO) off_sat = OFS_LO[OW-1:0];
        else                   off_sat = ofs[OW-1:0];
    end

    always_comb begin
        s_d       = s_q;
        lo_we     = 1'b0;
        hi_we     = 1'b0;
        coef_we   = 1'b0;
        div_start = 1'b0;
        div_num   = NW'(s_q.sum_l);
        div_den   = NW'(NPIX);
        s_d.v1    = corr_acc;
        s_d.p1    = pix_data;
        unique case (s_q.st)
            ST_CAPL, ST_CAPH: begin
                if (cap_acc) begin
                    lo_we     = (s_q.st == ST_CAPL);
                    hi_we     = (s_q.st == ST_CAPH);
                    s_d.armed = 1'b1;
                    s_d.idx   = pix_addr + 1'b1;
                    if (s_q.st == ST_CAPL)
                        s_d.sum_l = (pix_sof ? '0 : s_q.sum_l) + SW'(pix_data);
                    else
                        s_d.sum_h = (pix_sof ? '0 : s_q.sum_h) + SW'(pix_data);
                    if (last_pix) begin
                        s_d.st    = (s_q.st == ST_CAPL) ? ST_CAPH : ST_MEANL;
                        s_d.armed = 1'b0;
                        s_d.idx   = '0;
                    end
                end
            end
            ST_MEANL, ST_MEANH: begin
                if (s_q.st == ST_MEANH) div_num = NW'(s_q.sum_h);
                if (!s_q.launched) begin
                    div_start    = 1'b1;
                    s_d.launched = 1'b1;
                end else if (div_done) begin
                    s_d.launched = 1'b0;
                    if (s_q.st == ST_MEANL) begin
                        s_d.mean_l = div_quo[PW-1:0];
                        s_d.st     = ST_MEANH;
                    end else begin
                        s_d.mean_h = div_quo[PW-1:0];
                        s_d.cidx   = '0;
                        s_d.st     = ST_CRD;
                    end
                end
            end
            ST_CRD: s_d.st = ST_CGO;
            ST_CGO: begin
                s_d.li  = lo_rd;
                s_d.neg = dmean[PW] ^ dif[PW];
                div_num = NW'({abs_dm, {GF{1'b0}}});
                div_den = NW'(abs_dif);
                if (abs_dif == '0) begin
                    s_d.gain = UNITY;
                    s_d.st   = ST_CWR;
                end else begin
                    div_start = 1'b1;
                    s_d.st    = ST_CDIV;
                end
            end
            ST_CDIV: begin
                if (div_done) begin
                    if (s_q.neg)                 s_d.gain = '0;
                    else if (|div_quo[NW-1:GW])  s_d.gain = '1;
                    else                         s_d.gain = div_quo[GW-1:0];
                    s_d.st = ST_CWR;
                end
            end
            ST_CWR: begin
                coef_we = 1'b1;
                if (s_q.cidx == AW'(NPIX - 1)) begin
                    s_d.st  = ST_DONE;
                    s_d.idx = '0;
                end else begin
                    s_d.cidx = s_q.cidx + 1'b1;
                    s_d.st   = ST_CRD;
                end
            end
            ST_DONE: begin
                if (corr_acc) s_d.idx = last_pix ? '0 : pix_addr + 1'b1;
            end
            default: ;
        endcase
        if (cal_start) begin
            s_d.st       = ST_CAPL;
            s_d.armed    = 1'b0;
            s_d.launched = 1'b0;
            s_d.idx      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    nuc_ram #(.DW(PW), .DEPTH(NPIX), .AW(AW)) i_ref_lo (
        .clk(clk), .we(lo_we), .waddr(pix_addr), .wdata(pix_data),
        .raddr(s_q.cidx), .rdata(lo_rd)
    );

    nuc_ram #(.DW(PW), .DEPTH(NPIX), .AW(AW)) i_ref_hi (
        .clk(clk), .we(hi_we), .waddr(pix_addr), .wdata(pix_data),
        .raddr(s_q.cidx), .rdata(hi_rd)
    );

    nuc_ram #(.DW(CWID), .DEPTH(NPIX), .AW(AW)) i_coef (
        .clk(clk), .we(coef_we), .waddr(s_q.cidx), .wdata({s_q.gain, off_sat}),
        .raddr(pix_addr), .rdata(coef_rd)
    );

    nuc_div #(.NW(NW)) i_div (
        .clk(clk), .rst_n(rst_n), .abort(cal_start), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
    );

    nuc_apply #(.PW(PW), .GW(GW), .GF(GF), .OW(OW)) i_apply (
        .clk(clk), .rst_n(rst_n), .in_valid(s_q.v1), .in_pix(s_q.p1),
        .gain(coef_rd[CWID-1:OW]), .offset($signed(coef_rd[OW-1:0])),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    assign cal_done = (s_q.st == ST_DONE);
    assign cal_busy = (s_q.st != ST_DONE) && (s_q.st != ST_IDLE);

endmodule

// File: rtl/nuc_core_chk.sv
module nuc_core_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_start,
    input logic pix_valid,
    input logic cal_busy,
    input logic cal_done,
    input logic out_valid
);

    // R2
    start_enters_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (cal_busy && !cal_done));

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> cal_done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(cal_busy));

    // R10
    out_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(cal_done, 2));

    // R9
    out_needs_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pix_valid, 2) && !$past(cal_start, 2)));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !cal_busy);

endmodule

bind nuc_core nuc_core_chk i_nuc_core_chk (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .pix_valid(pix_valid),
    .cal_busy(cal_busy), .cal_done(cal_done), .out_valid(out_valid)
);

// File: tb/test_nuc_core.sv
module test_nuc_core;

    localparam int W    = 16;
    localparam int H    = 8;
    localparam int NPIX = W * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_sof = 1'b0;
    logic [13:0] pix_data = '0;
    logic        cal_busy, cal_done, out_valid;
    logic [13:0] out_pix;

    always #2 clk = ~clk;

    nuc_core #(.IMG_W(W), .IMG_H(H)) i_nuc_core (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .pix_valid(pix_valid),
        .pix_sof(pix_sof), .pix_data(pix_data), .cal_busy(cal_busy),
        .cal_done(cal_done), .out_valid(out_valid), .out_pix(out_pix)
    );

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    int    lo_ref [NPIX];
    int    hi_ref [NPIX];
    int    gain_m [NPIX];
    int    off_m  [NPIX];
    string cls_tag[NPIX];
    int    fbuf   [NPIX];
    int    mean_l, mean_h;
    string frame_tag = "R10";
    bit    done_seen = 0;
    int    m_idx = 0;
    int    ov_count = 0;
    bit    pv [2];
    int    pd [2];
    string pt [2];

    function automatic void chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    // Behavioural coefficient model from the reference frames the bench sent.
    function automatic void compute_coefs();
        longint sl = 0, sh = 0;
        for (int i = 0; i < NPIX; i++) begin
            sl += lo_ref[i];
            sh += hi_ref[i];
        end
        mean_l = int'(sl / NPIX);
        mean_h = int'(sh / NPIX);
        for (int i = 0; i < NPIX; i++) begin
            longint d, dm, g, o, q;
            string t = "";
            d  = hi_ref[i] - lo_ref[i];
            dm = mean_h - mean_l;
            if (d == 0) begin
                g = 16384; t = "R6";
            end else if (dm == 0) begin
                g = 0;
            end else if ((dm < 0) != (d < 0)) begin
                g = 0; t = "R5";
            end else begin
                q = ((dm < 0 ? -dm : dm) * 16384) / (d < 0 ? -d : d);
                if (q > 65535) begin q = 65535; t = "R5"; end
                g = q;
            end
            o = mean_l - (g * lo_ref[i]) / 16384;
            if (o < -32768) begin o = -32768; t = "R7"; end
            if (o > 32767)  begin o = 32767;  t = "R7"; end
            gain_m[i]  = int'(g);
            off_m[i]   = int'(o);
            cls_tag[i] = t;
        end
    endfunction

    // Reference model: one expected entry per clock, two cycles of delay.
    always @(posedge clk) begin
        bit     acc;
        int     idx;
        longint v;
        string  tg;
        if (!rst_n) begin
            pv[0] = 0; pv[1] = 0; m_idx = 0;
        end else begin
            acc = pix_valid && !cal_start && done_seen;
            v   = 0;
            tg  = frame_tag;
            if (acc) begin
                idx = pix_sof ? 0 : m_idx;
                v = (longint'(gain_m[idx]) * int'(pix_data)) / 16384 + off_m[idx];
                if (v < 0) v = 0;
                if (v > 16383) v = 16383;
                m_idx = (idx + 1) % NPIX;
                if (cls_tag[idx] != "") tg = cls_tag[idx];
            end
            if (cal_start) m_idx = 0;
            pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
            pv[0] = acc;   pd[0] = int'(v); pt[0] = tg;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (out_valid !== pv[1] || (pv[1] && int'(out_pix) !== pd[1])) begin
                failures++;
                $display("FAIL %s actual=%0d/%0d expected=%0d/%0d",
                         pt[1], out_valid, out_pix, pv[1], pd[1]);
            end
            if (out_valid) ov_count++;
        end
        done_seen = cal_done;
    end

    task automatic send_frame(bit gaps, int hit, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_sof   = (i == 0);
            pix_data  = 14'(fbuf[i]);
            cal_start = (i == hit);
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                pix_valid = 1'b0;
                cal_start = 1'b0;
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        cal_start = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!cal_done && n < NPIX * 60) begin
            @(negedge clk);
            n++;
        end
        chk(cal_done === 1'b1, "R8 done", int'(cal_done), 1);
        chk(cal_busy === 1'b0, "R8 busy", int'(cal_busy), 0);
    endtask

    task automatic fill_ramp();
        for (int i = 0; i < NPIX; i++) fbuf[i] = (i * 131) % 16384;
        fbuf[0] = 0;
        fbuf[1] = 16383;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cal_busy === 1'b0, "R1 busy", int'(cal_busy), 0);
        chk(cal_done === 1'b0, "R1 done", int'(cal_done), 0);
        chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);

        // R10: stream before any calibration
        frame_tag = "R10";
        fill_ramp();
        send_frame(0, -1, NPIX);
        repeat (3) @(negedge clk);
        chk(ov_count == 0, "R10 outputs", ov_count, 0);

        // R2: start of calibration
        pulse_start();
        chk(cal_busy === 1'b1 && cal_done === 1'b0, "R2 enter", int'(cal_busy), 1);

        // R3: stray pixels before the frame marker are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_sof = 1'b0; pix_data = 14'(9999);
        end
        for (int i = 0; i < NPIX; i++) begin
            lo_ref[i] = 1000 + (i * 37) % 200;
            if (i % 17 == 0)      hi_ref[i] = lo_ref[i];
            else if (i % 29 == 5) hi_ref[i] = lo_ref[i] - 100;
            else if (i % 23 == 3) hi_ref[i] = lo_ref[i] + 1;
            else                  hi_ref[i] = lo_ref[i] + 3000 + (i * 53) % 500;
        end
        fbuf = lo_ref;
        send_frame(1, -1, NPIX);
        fbuf = hi_ref;
        send_frame(0, -1, NPIX);
        chk(cal_done === 1'b0, "R8 early", int'(cal_done), 0);
        compute_coefs();
        wait_done();

        // R4: cold frame maps to the cold mean
        frame_tag = "R4";
        fbuf = lo_ref;
        send_frame(0, -1, NPIX);
        // R3: hot frame through correction
        frame_tag = "R3";
        fbuf = hi_ref;
        send_frame(1, -1, NPIX);
        // R11: back-to-back ramp with extremes (R9 clamping)
        frame_tag = "R11";
        fill_ramp();
        send_frame(0, -1, NPIX);
        frame_tag = "R9";
        send_frame(1, -1, NPIX);
        repeat (3) @(negedge clk);
        chk(cal_done === 1'b1, "R8 sticky", int'(cal_done), 1);

        // R2: start collides with an accepted pixel mid-frame
        frame_tag = "R2";
        send_frame(0, 10, NPIX);
        chk(cal_busy === 1'b1 && cal_done === 1'b0, "R2 collide", int'(cal_done), 0);

        // R2: restart part-way through a cold capture
        for (int i = 0; i < NPIX; i++) fbuf[i] = 5000;
        send_frame(0, -1, 20);
        pulse_start();
        for (int i = 0; i < NPIX; i++) begin
            if (i % 19 == 7) begin
                lo_ref[i] = 12000; hi_ref[i] = 12001;
            end else begin
                lo_ref[i] = 2000 + (i * 11) % 300;
                hi_ref[i] = lo_ref[i] + 5000 + (i * 7) % 400;
            end
        end
        fbuf = lo_ref;
        send_frame(0, -1, NPIX);
        fbuf = hi_ref;
        send_frame(1, -1, NPIX);
        compute_coefs();
        wait_done();

        // R7: clipped offsets in the new coefficient set
        frame_tag = "R7";
        fill_ramp();
        for (int i = 0; i < NPIX; i++) if (i % 19 == 7) fbuf[i] = (i % 2) ? 16383 : 12000;
        send_frame(0, -1, NPIX);
        frame_tag = "R4";
        fbuf = lo_ref;
        send_frame(1, -1, NPIX);
        repeat (4) @(negedge clk);
        chk(cal_done === 1'b1, "R8 final", int'(cal_done), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule